// File: doc/BRIEF.md
# Shared-Memory Ring FIFO Accessor

This block lets a host side move bytes to and from a processor through ring buffers that sit in the processor's own memory. Each ring is described by a base address. Three header bytes sit directly below the base: the index mask (buffer length minus one), the producer index and the consumer index. The data slots start at the base. The block keeps a local copy of each ring's base, mask and indices. It performs every memory access through a simple strobe/acknowledge port, and only while it owns the memory bus through a request/grant pair.

The host issues one command at a time: configure a ring, put a byte, get a byte (blocking or non-blocking), or ask whether a ring is empty or full. Because the far side updates its own index in memory, each check re-reads that index over the bus. A get or put reads the other side's index, moves the data and writes its own updated index back, all within one bus ownership. A blocking operation that cannot proceed gives the bus back and then asks for it again until it can. A base address of zero marks a ring as unconfigured.

Top module: `ring_fifo_access`

## Requirements
- R1: After reset, cmd_ready is 1, and bus_req, mem_stb and rsp_valid are 0. Every ring is unconfigured.
- R2: With base B and index width equal to the data width, the header bytes are: mask at B-3, producer index at B-2, consumer index at B-1. Data slot i is at B+i, and an index advances as (i+1) AND mask.
- R3: Configure (cmd_op 0) stores cmd_base for the selected ring. If cmd_base is non-zero, the block loads mask, producer index and consumer index during one bus ownership. A zero base leaves the ring unconfigured and touches no bus.
- R4: Empty (cmd_op 4) answers rsp_flag=1 exactly when the producer index read from memory equals the cached consumer index.
- R5: Full (cmd_op 5) answers rsp_flag=1 exactly when (cached producer index + 1) AND mask equals the consumer index read from memory.
- R6: Non-blocking get (cmd_op 3) on a non-empty ring returns the byte at B+out with rsp_flag=0. It advances out and writes the new value to B-1, all in one bus ownership. On an empty ring it returns rsp_flag=1 and writes no memory.
- R7: Blocking get (cmd_op 2) releases the bus and retries while the ring is empty. Once data appears, it completes as in R6.
- R8: Put (cmd_op 1) releases the bus and retries while the ring is full. It then writes cmd_data to B+in, advances in, and writes the new value to B-2.
- R9: On an unconfigured ring, empty, full, both gets and put answer rsp_flag=1. The response comes in the cycle after acceptance, and bus_req stays 0.
- R10: mem_stb is high only while bus_req and bus_gnt are both high. An access keeps mem_stb and mem_addr steady until mem_ack.
- R11: cmd_ready is 0 from acceptance until the response. rsp_valid is a one-cycle pulse, and bus_req is already 0 when it appears.
- R12: Command codes 6 and 7 are answered with rsp_flag=1 in the cycle after acceptance, with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; command taken when both high |
| cmd_op | input | 3 | Command code (see R3 to R12) |
| cmd_fifo | input | FIDX_W (1) | Ring selector |
| cmd_base | input | ADDR_W (16) | Base address for configure |
| cmd_data | input | DATA_W (8) | Byte to put |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_flag | output | 1 | Empty/full answer, no-data or rejected |
| rsp_data | output | DATA_W (8) | Byte obtained by a get |
| bus_req | output | 1 | Memory bus ownership request |
| bus_gnt | input | 1 | Memory bus ownership granted |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W (16) | Access address |
| mem_wdata | output | DATA_W (8) | Write byte |
| mem_ack | input | 1 | Access complete; read byte valid |
| mem_rdata | input | DATA_W (8) | Read byte |

## Verification
Commands that never need the bus (an unconfigured ring, a bad code, configuring with base zero) must answer exactly one cycle after the acceptance edge. The bench counts negative edges from acceptance and requires a count of one. Commands that use the bus depend on a grant and acknowledges that the memory model delays at random. For these the bench waits for the rsp_valid pulse, sampling at the falling edge. It then checks the response, the bus_req level, the number of bus ownerships taken, and the header and slot bytes in its memory image against values its own ring model predicts.

// File: rtl/rfa_pkg.sv
// Shared types for the ring FIFO accessor: command codes and sequencer states.
package rfa_pkg;
    typedef enum logic [2:0] {
        OP_INIT     = 3'd0,
        OP_PUT      = 3'd1,
        OP_GET_WAIT = 3'd2,
        OP_GET_TRY  = 3'd3,
        OP_EMPTY    = 3'd4,
        OP_FULL     = 3'd5
    } rfa_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACQ,
        ST_RD_MASK,
        ST_RD_IN,
        ST_RD_OUT,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_WR_IDX,
        ST_REL,
        ST_DONE
    } rfa_state_e;
endpackage

// File: rtl/rfa_desc_file.sv
// Descriptor store: one base/mask/producer/consumer record per ring.
// Assumes at most one field set per write select in a cycle per field kind;
// reads are combinational on rd_sel. A zero base means unconfigured.
module rfa_desc_file #(
    parameter int NUM_FIFO = 2,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 8,
    parameter int FIDX_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FIDX_W-1:0] rd_sel,
    output logic [ADDR_W-1:0] rd_base,
    output logic [IDX_W-1:0]  rd_mask,
    output logic [IDX_W-1:0]  rd_in,
    output logic [IDX_W-1:0]  rd_out,
    input  logic [FIDX_W-1:0] wr_sel,
    input  logic              wr_base_en,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic              wr_mask_en,
    input  logic [IDX_W-1:0]  wr_mask,
    input  logic              wr_in_en,
    input  logic [IDX_W-1:0]  wr_in,
    input  logic              wr_out_en,
    input  logic [IDX_W-1:0]  wr_out
);
    logic [ADDR_W-1:0] base_a [NUM_FIFO];
    logic [IDX_W-1:0]  mask_a [NUM_FIFO];
    logic [IDX_W-1:0]  in_a   [NUM_FIFO];
    logic [IDX_W-1:0]  out_a  [NUM_FIFO];

    for (genvar g = 0; g < NUM_FIFO; g++) begin : g_slot
        logic [ADDR_W-1:0] base_r;
        logic [IDX_W-1:0]  mask_r, in_r, out_r;
        logic              hit;
        assign hit = (wr_sel == FIDX_W'(g));

        // Update this ring's record on a selected write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_r <= '0;
                mask_r <= '0;
                in_r   <= '0;
                out_r  <= '0;
            end else if (hit) begin
                if (wr_base_en) base_r <= wr_base;
                if (wr_mask_en) mask_r <= wr_mask;
                if (wr_in_en)   in_r   <= wr_in;
                if (wr_out_en)  out_r  <= wr_out;
            end
        end

        assign base_a[g] = base_r;
        assign mask_a[g] = mask_r;
        assign in_a[g]   = in_r;
        assign out_a[g]  = out_r;
    end

    // Present the selected ring's record.
    always_comb begin
        rd_base = base_a[rd_sel];
        rd_mask = mask_a[rd_sel];
        rd_in   = in_a[rd_sel];
        rd_out  = out_a[rd_sel];
    end
endmodule

// File: rtl/rfa_mem_port.sv
// Single-access memory port: a go pulse latches one access and raises the
// strobe until acknowledged. Assumes go only arrives while the port is idle.
module rfa_mem_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              acc_done,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    // Hold the access on the bus until the memory acknowledges it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_stb   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (acc_go) begin
            mem_stb   <= 1'b1;
            mem_we    <= acc_we;
            mem_addr  <= acc_addr;
            mem_wdata <= acc_wdata;
        end else if (mem_stb && mem_ack) begin
            mem_stb   <= 1'b0;
        end
    end

    assign acc_done  = mem_stb && mem_ack;
    assign acc_rdata = mem_rdata;

    // R10
    stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && !mem_ack) |=> (mem_stb && $stable(mem_addr)));
    // R10
    go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> !mem_stb);
endmodule

// File: rtl/rfa_seq.sv
// Command sequencer: runs one ring command at a time, owning the bus for
// each memory phase and retrying blocking commands by release/re-acquire.
// Assumes the descriptor store reads combinationally and the memory port
// signals completion with acc_done in the acknowledge cycle.
module rfa_seq #(
    parameter int NUM_FIFO = 2,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int FIDX_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [FIDX_W-1:0] cmd_fifo,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic              rsp_flag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [FIDX_W-1:0] d_sel,
    input  logic [ADDR_W-1:0] d_base,
    input  logic [DATA_W-1:0] d_mask,
    input  logic [DATA_W-1:0] d_in,
    input  logic [DATA_W-1:0] d_out,
    output logic              wr_base_en,
    output logic [ADDR_W-1:0] wr_base,
    output logic              wr_mask_en,
    output logic [DATA_W-1:0] wr_mask,
    output logic              wr_in_en,
    output logic [DATA_W-1:0] wr_in,
    output logic              wr_out_en,
    output logic [DATA_W-1:0] wr_out,
    output logic              acc_go,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_done,
    input  logic [DATA_W-1:0] acc_rdata
);
    import rfa_pkg::*;

    rfa_state_e        st_q;
    logic [2:0]        op_q;
    logic [FIDX_W-1:0] sel_q;
    logic [DATA_W-1:0] dat_q;
    logic              flag_q, retry_q, busy_q;
    logic              is_acc, is_get, op_is_ring;
    logic [DATA_W-1:0] nxt_in, nxt_out;

    // Decode state classes and advanced indices.
    always_comb begin
        is_acc = (st_q == ST_RD_MASK) || (st_q == ST_RD_IN) || (st_q == ST_RD_OUT) ||
                 (st_q == ST_RD_DATA) || (st_q == ST_WR_DATA) || (st_q == ST_WR_IDX);
        is_get = (op_q == OP_GET_WAIT) || (op_q == OP_GET_TRY);
        op_is_ring = (cmd_op >= 3'd1) && (cmd_op <= 3'd5);
        nxt_in  = (d_in + 1'b1) & d_mask;
        nxt_out = (d_out + 1'b1) & d_mask;
        d_sel   = (st_q == ST_IDLE) ? cmd_fifo : sel_q;
    end

    // Drive the memory access for the current phase.
    always_comb begin
        acc_go    = is_acc && !busy_q;
        acc_we    = (st_q == ST_WR_DATA) || (st_q == ST_WR_IDX);
        acc_wdata = dat_q;
        case (st_q)
            ST_RD_MASK: acc_addr = d_base - ADDR_W'(3);
            ST_RD_IN:   acc_addr = d_base - ADDR_W'(2);
            ST_RD_OUT:  acc_addr = d_base - ADDR_W'(1);
            ST_RD_DATA: acc_addr = d_base + ADDR_W'(d_out);
            ST_WR_DATA: acc_addr = d_base + ADDR_W'(d_in);
            ST_WR_IDX:  acc_addr = (op_q == OP_PUT) ? d_base - ADDR_W'(2)
                                                    : d_base - ADDR_W'(1);
            default:    acc_addr = d_base;
        endcase
        if (st_q == ST_WR_IDX) acc_wdata = (op_q == OP_PUT) ? d_in : d_out;
    end

    // Descriptor updates from commands and completed reads.
    always_comb begin
        wr_base_en = (st_q == ST_IDLE) && cmd_valid && (cmd_op == OP_INIT);
        wr_base    = cmd_base;
        wr_mask_en = (st_q == ST_RD_MASK) && acc_done;
        wr_mask    = acc_rdata;
        wr_in_en   = ((st_q == ST_RD_IN) && acc_done && (op_q == OP_INIT)) ||
                     ((st_q == ST_WR_DATA) && acc_done);
        wr_in      = (st_q == ST_WR_DATA) ? nxt_in : acc_rdata;
        wr_out_en  = ((st_q == ST_RD_OUT) && acc_done && (op_q == OP_INIT)) ||
                     ((st_q == ST_RD_DATA) && acc_done);
        wr_out     = (st_q == ST_RD_DATA) ? nxt_out : acc_rdata;
    end

    // Host-facing and bus-facing outputs.
    always_comb begin
        cmd_ready = (st_q == ST_IDLE);
        rsp_valid = (st_q == ST_DONE);
        rsp_flag  = flag_q;
        rsp_data  = dat_q;
        bus_req   = (st_q == ST_ACQ) || is_acc;
    end

    // Track whether the current phase's access is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (acc_done) busy_q <= 1'b0;
        else if (acc_go)   busy_q <= 1'b1;
    end

    // Main command state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            op_q    <= '0;
            sel_q   <= '0;
            dat_q   <= '0;
            flag_q  <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (cmd_valid) begin
                    op_q    <= cmd_op;
                    sel_q   <= cmd_fifo;
                    dat_q   <= cmd_data;
                    flag_q  <= 1'b0;
                    retry_q <= 1'b0;
                    if (cmd_op == OP_INIT) begin
                        st_q <= (cmd_base == '0) ? ST_DONE : ST_ACQ;
                    end else if (!op_is_ring || d_base == '0) begin
                        flag_q <= 1'b1;
                        st_q   <= ST_DONE;
                    end else begin
                        st_q <= ST_ACQ;
                    end
                end
                ST_ACQ: if (bus_gnt) begin
                    if (op_q == OP_INIT)                   st_q <= ST_RD_MASK;
                    else if (is_get || op_q == OP_EMPTY)   st_q <= ST_RD_IN;
                    else                                   st_q <= ST_RD_OUT;
                end
                ST_RD_MASK: if (acc_done) st_q <= ST_RD_IN;
                ST_RD_IN: if (acc_done) begin
                    if (op_q == OP_INIT) begin
                        st_q <= ST_RD_OUT;
                    end else if (op_q == OP_EMPTY) begin
                        flag_q <= (acc_rdata == d_out);
                        st_q   <= ST_REL;
                    end else if (acc_rdata == d_out) begin
                        if (op_q == OP_GET_WAIT) retry_q <= 1'b1;
                        else                     flag_q  <= 1'b1;
                        st_q <= ST_REL;
                    end else begin
                        st_q <= ST_RD_DATA;
                    end
                end
                ST_RD_OUT: if (acc_done) begin
                    if (op_q == OP_INIT) begin
                        st_q <= ST_REL;
                    end else if (op_q == OP_FULL) begin
                        flag_q <= (nxt_in == acc_rdata);
                        st_q   <= ST_REL;
                    end else if (nxt_in == acc_rdata) begin
                        retry_q <= 1'b1;
                        st_q    <= ST_REL;
                    end else begin
                        st_q <= ST_WR_DATA;
                    end
                end
                ST_RD_DATA: if (acc_done) begin
                    dat_q <= acc_rdata;
                    st_q  <= ST_WR_IDX;
                end
                ST_WR_DATA: if (acc_done) st_q <= ST_WR_IDX;
                ST_WR_IDX:  if (acc_done) st_q <= ST_REL;
                ST_REL: if (!bus_gnt) begin
                    if (retry_q) begin
                        retry_q <= 1'b0;
                        st_q    <= ST_ACQ;
                    end else begin
                        st_q <= ST_DONE;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    unconf_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid && op_is_ring && d_base == '0) |=> (rsp_valid && rsp_flag));
    // R11
    rsp_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !bus_req);
    // R11
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && cmd_valid) |=> !cmd_ready);
endmodule

// File: rtl/ring_fifo_access.sv
// Top of the ring FIFO accessor: descriptor store, sequencer and memory port.
// Assumes the memory side grants the bus through bus_gnt and acknowledges
// each strobed access with mem_ack (read data valid in that cycle).
module ring_fifo_access #(
    parameter int NUM_FIFO = 2,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int FIDX_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [FIDX_W-1:0] cmd_fifo,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              rsp_valid,
    output logic              rsp_flag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_stb,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [FIDX_W-1:0] d_sel;
    logic [ADDR_W-1:0] d_base, wr_base;
    logic [DATA_W-1:0] d_mask, d_in, d_out, wr_mask, wr_in, wr_out;
    logic              wr_base_en, wr_mask_en, wr_in_en, wr_out_en;
    logic              acc_go, acc_we, acc_done;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] acc_wdata, acc_rdata;

    rfa_desc_file #(.NUM_FIFO(NUM_FIFO), .ADDR_W(ADDR_W), .IDX_W(DATA_W), .FIDX_W(FIDX_W)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .rd_sel(d_sel), .rd_base(d_base), .rd_mask(d_mask), .rd_in(d_in), .rd_out(d_out),
        .wr_sel(d_sel),
        .wr_base_en(wr_base_en), .wr_base(wr_base),
        .wr_mask_en(wr_mask_en), .wr_mask(wr_mask),
        .wr_in_en(wr_in_en), .wr_in(wr_in),
        .wr_out_en(wr_out_en), .wr_out(wr_out)
    );

    rfa_seq #(.NUM_FIFO(NUM_FIFO), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIDX_W(FIDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_fifo(cmd_fifo), .cmd_base(cmd_base), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt),
        .d_sel(d_sel), .d_base(d_base), .d_mask(d_mask), .d_in(d_in), .d_out(d_out),
        .wr_base_en(wr_base_en), .wr_base(wr_base),
        .wr_mask_en(wr_mask_en), .wr_mask(wr_mask),
        .wr_in_en(wr_in_en), .wr_in(wr_in),
        .wr_out_en(wr_out_en), .wr_out(wr_out),
        .acc_go(acc_go), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata)
    );

    rfa_mem_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .acc_go(acc_go), .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_done(acc_done), .acc_rdata(acc_rdata),
        .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // R10
    mem_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> (bus_req && bus_gnt));
endmodule

// File: tb/ring_fifo_access_tb_top.sv
module ring_fifo_access_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [0:0] cmd_fifo = '0;
    logic [ADDR_W-1:0] cmd_base = '0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic rsp_valid, rsp_flag;
    logic [DATA_W-1:0] rsp_data;
    logic bus_req;
    logic bus_gnt = 1'b0;
    logic mem_stb, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    ring_fifo_access dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_fifo(cmd_fifo), .cmd_base(cmd_base), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_flag(rsp_flag), .rsp_data(rsp_data),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_stb(mem_stb), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [0:1023];
    int errors = 0, checks = 0;
    int own_cnt = 0, viol = 0;
    logic req_prev = 1'b0, pend = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [ADDR_W-1:0] fb [2];
    logic [7:0] fmask [2], hin [2], hout [2];

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory and bus-grant model acting as the processor side.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req && !req_prev) own_cnt++;
            req_prev = bus_req;
            if (!bus_req) bus_gnt = 1'b0;
            else if (!bus_gnt && ($urandom % 2 == 0)) bus_gnt = 1'b1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_stb) begin
                if (!bus_gnt || !bus_req) viol++;
                if (!pend) begin pend = 1'b1; paddr = mem_addr; end
                else if (paddr != mem_addr) viol++;
                if ($urandom % 3 != 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
                    else mem_rdata = mem[mem_addr[9:0]];
                    pend = 1'b0;
                end
            end
        end
    end

    function automatic logic [9:0] ha(input int f, input int off);
        return 10'(int'(fb[f]) + off);
    endfunction

    function automatic bit m_empty(input int f);
        return mem[ha(f, -2)] == hout[f];
    endfunction

    function automatic bit m_full(input int f);
        return ((hin[f] + 8'd1) & fmask[f]) == mem[ha(f, -1)];
    endfunction

    task automatic cpu_push(input int f, input logic [7:0] v);
        logic [7:0] i;
        i = mem[ha(f, -2)];
        if (((i + 8'd1) & fmask[f]) != mem[ha(f, -1)]) begin
            mem[ha(f, int'(i))] = v;
            mem[ha(f, -2)] = (i + 8'd1) & fmask[f];
        end
    endtask

    task automatic cpu_pop(input int f);
        logic [7:0] o;
        o = mem[ha(f, -1)];
        if (o != mem[ha(f, -2)]) mem[ha(f, -1)] = (o + 8'd1) & fmask[f];
    endtask

    task automatic do_cmd(input logic [2:0] op, input int f, input logic [15:0] base,
                          input logic [7:0] d, output bit flag, output logic [7:0] q,
                          output int lat);
        @(negedge clk);
        chk("R11 ready before command", cmd_ready == 1'b1, cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_fifo = 1'(f); cmd_base = base; cmd_data = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        if (!rsp_valid)
            chk("R11 ready low while busy", cmd_ready == 1'b0, cmd_ready, 0);
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        chk("R11 bus released at response", bus_req == 1'b0, bus_req, 0);
        flag = rsp_flag;
        q = rsp_data;
        @(negedge clk);
        chk("R11 single pulse", rsp_valid == 1'b0, rsp_valid, 0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit fl;
        logic [7:0] q;
        int lat, o0;
        void'($urandom(32'h5EED));
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        fb[0] = 16'h0100; fb[1] = 16'h0200;
        fmask[0] = 8'd7; fmask[1] = 8'd7;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd_ready", cmd_ready == 1'b1, cmd_ready, 1);
        chk("R1 bus_req", bus_req == 1'b0, bus_req, 0);
        chk("R1 mem_stb", mem_stb == 1'b0, mem_stb, 0);
        chk("R1 rsp_valid", rsp_valid == 1'b0, rsp_valid, 0);
        rst_n = 1'b1;

        // R9 unconfigured rings answer at once with no bus use
        o0 = own_cnt;
        for (int op = 1; op <= 5; op++) begin
            do_cmd(3'(op), op % 2, 16'h0, 8'h11, fl, q, lat);
            chk("R9 unconfigured flag", fl == 1'b1, fl, 1);
            chk("R9 unconfigured latency", lat == 1, lat, 1);
        end
        // R12 unused codes
        do_cmd(3'd6, 0, 16'h0, 8'h0, fl, q, lat);
        chk("R12 code 6 flag", fl == 1'b1 && lat == 1, {fl, 8'(lat)}, 9'h101);
        do_cmd(3'd7, 1, 16'h0, 8'h0, fl, q, lat);
        chk("R12 code 7 flag", fl == 1'b1 && lat == 1, {fl, 8'(lat)}, 9'h101);
        chk("R9 no bus use", own_cnt == o0, own_cnt - o0, 0);

        // R2/R3 configure both rings from header bytes
        mem[ha(0, -3)] = 8'd7; mem[ha(0, -2)] = 8'd5; mem[ha(0, -1)] = 8'd5;
        mem[ha(1, -3)] = 8'd7; mem[ha(1, -2)] = 8'd6; mem[ha(1, -1)] = 8'd2;
        hin[0] = 8'd5; hout[0] = 8'd5; hin[1] = 8'd6; hout[1] = 8'd2;
        for (int f = 0; f < 2; f++) begin
            o0 = own_cnt;
            do_cmd(3'd0, f, fb[f], 8'h0, fl, q, lat);
            chk("R3 configure one ownership", own_cnt - o0 == 1, own_cnt - o0, 1);
        end

        // R4 empty, R5 full after configure
        do_cmd(3'd4, 0, 16'h0, 8'h0, fl, q, lat);
        chk("R4 empty ring0", fl == 1'b1, fl, 1);
        do_cmd(3'd5, 1, 16'h0, 8'h0, fl, q, lat);
        chk("R5 not full ring1", fl == 1'b0, fl, 0);

        // R6 non-blocking get on empty ring
        do_cmd(3'd3, 0, 16'h0, 8'h0, fl, q, lat);
        chk("R6 empty get no-data", fl == 1'b1, fl, 1);
        chk("R6 consumer index untouched", mem[ha(0, -1)] == 8'd5, mem[ha(0, -1)], 5);

        // R2/R6 gets across the wrap point
        cpu_push(0, 8'hA1); cpu_push(0, 8'hB2); cpu_push(0, 8'hC3);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] exp;
            exp = mem[ha(0, int'(hout[0]))];
            o0 = own_cnt;
            do_cmd(3'd3, 0, 16'h0, 8'h0, fl, q, lat);
            hout[0] = (hout[0] + 8'd1) & fmask[0];
            chk("R6 get data", fl == 1'b0 && q == exp, q, exp);
            chk("R2 consumer index at base-1", mem[ha(0, -1)] == hout[0], mem[ha(0, -1)], hout[0]);
            chk("R6 one ownership", own_cnt - o0 == 1, own_cnt - o0, 1);
        end
        chk("R2 consumer index wrapped", hout[0] == 8'd0, hout[0], 0);

        // R7 blocking get waits for data
        o0 = own_cnt;
        fork
            do_cmd(3'd2, 0, 16'h0, 8'h0, fl, q, lat);
            begin repeat (40) @(negedge clk); cpu_push(0, 8'hA5); end
        join
        hout[0] = (hout[0] + 8'd1) & fmask[0];
        chk("R7 blocking get data", fl == 1'b0 && q == 8'hA5, q, 8'hA5);
        chk("R7 retried ownerships", own_cnt - o0 > 1, own_cnt - o0, 2);
        chk("R7 consumer written back", mem[ha(0, -1)] == hout[0], mem[ha(0, -1)], hout[0]);

        // R8 puts until full, with wrap
        for (int k = 0; k < 3; k++) begin
            logic [7:0] v;
            v = 8'h30 + 8'(k);
            do_cmd(3'd1, 1, 16'h0, v, fl, q, lat);
            chk("R8 slot written", mem[ha(1, int'(hin[1]))] == v, mem[ha(1, int'(hin[1]))], v);
            hin[1] = (hin[1] + 8'd1) & fmask[1];
            chk("R2 producer index at base-2", mem[ha(1, -2)] == hin[1], mem[ha(1, -2)], hin[1]);
        end
        do_cmd(3'd5, 1, 16'h0, 8'h0, fl, q, lat);
        chk("R5 full ring1", fl == 1'b1, fl, 1);

        // R8 put waits while full
        fork
            do_cmd(3'd1, 1, 16'h0, 8'h3C, fl, q, lat);
            begin repeat (40) @(negedge clk); cpu_pop(1); end
        join
        chk("R8 blocked put slot", mem[ha(1, 1)] == 8'h3C, mem[ha(1, 1)], 8'h3C);
        hin[1] = (hin[1] + 8'd1) & fmask[1];
        chk("R8 blocked put index", mem[ha(1, -2)] == hin[1], mem[ha(1, -2)], hin[1]);

        // Random mix checked against the bench ring model
        for (int it = 0; it < 250; it++) begin
            int sel;
            sel = int'($urandom % 7);
            case (sel)
                0: cpu_push(0, 8'($urandom));
                1: cpu_pop(1);
                2: begin
                    bit e;
                    logic [7:0] exp;
                    e = m_empty(0);
                    exp = mem[ha(0, int'(hout[0]))];
                    do_cmd(3'd3, 0, 16'h0, 8'h0, fl, q, lat);
                    if (e) chk("R6 random empty get", fl == 1'b1, fl, 1);
                    else begin
                        hout[0] = (hout[0] + 8'd1) & fmask[0];
                        chk("R6 random get", fl == 1'b0 && q == exp, q, exp);
                        chk("R6 random writeback", mem[ha(0, -1)] == hout[0], mem[ha(0, -1)], hout[0]);
                    end
                end
                3: if (!m_full(1)) begin
                    logic [7:0] v;
                    v = 8'($urandom);
                    do_cmd(3'd1, 1, 16'h0, v, fl, q, lat);
                    chk("R8 random put", mem[ha(1, int'(hin[1]))] == v, mem[ha(1, int'(hin[1]))], v);
                    hin[1] = (hin[1] + 8'd1) & fmask[1];
                end
                4: begin
                    int f;
                    bit e;
                    f = int'($urandom % 2);
                    e = m_empty(f);
                    do_cmd(3'd4, f, 16'h0, 8'h0, fl, q, lat);
                    chk("R4 random empty", fl == e, fl, e);
                end
                default: begin
                    int f;
                    bit u;
                    f = int'($urandom % 2);
                    u = m_full(f);
                    do_cmd(3'd5, f, 16'h0, 8'h0, fl, q, lat);
                    chk("R5 random full", fl == u, fl, u);
                end
            endcase
        end

        // R3 configuring with base zero unconfigures the ring
        do_cmd(3'd0, 0, 16'h0, 8'h0, fl, q, lat);
        chk("R3 zero base latency", lat == 1, lat, 1);
        do_cmd(3'd4, 0, 16'h0, 8'h0, fl, q, lat);
        chk("R9 reconfigured empty", fl == 1'b1 && lat == 1, {fl, 8'(lat)}, 9'h101);

        chk("R10 strobe only while owned and steady", viol == 0, viol, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule